// File: doc/BRIEF.md
# Video Luma/Chroma Digital Gain Control

This block scales digitized video samples by a programmable gain after the converter. It has two independent gain units, one for the luma stream and one for the chroma stream. Each unit multiplies its 9-bit sample by a 12-bit unsigned gain word. The gain word has 2 integer bits and 10 fraction bits, so 0x400 is unity. The product is rounded to the nearest output step and clamped at the top of the 9-bit range, so it never wraps. A sample and its valid flag leave the block exactly two clock cycles after they enter.

Each unit takes its gain from one of several sources, chosen by a control register:
- a manual gain register;
- a small automatic loop, which nudges the gain by one LSB every time a measured line amplitude arrives, comparing that amplitude with a target and staying between a floor and a ceiling;
- for chroma only, the luma unit's active gain.

A freeze bit in the same control register stops both loops, so the gain in effect at that moment stays applied. The gain each unit is currently applying can always be read on a dedicated port.

Top module: `vid_gain_ctrl`

## Requirements
- R1: After reset both read-back gains are 0x400, both paths are in automatic mode, freeze is clear, and `out_vld` is low.
- R2: A sample accepted with `in_vld` high appears on `y_out`/`c_out`, with `out_vld` high, two clock edges later. Its value is (x*g + 512) >> 10, where g is the path's active gain in the cycle the sample is accepted.
- R3: A result above 511 is output as 511. For example, x=511 with g=0xFFF gives 511.
- R4: A control write with `ctl_y_manual`=1 selects manual luma gain. A control write with `ctl_c_sel`=01 selects manual chroma gain. Writing `man_gain` with `man_y_wr` or `man_c_wr` sets the manual value. A manual gain applies from the next sample, and the read-back port shows it.
- R5: In automatic mode with freeze clear, each measurement strobe changes the gain by exactly one LSB:
  - if the measurement is below the target, the gain rises by one;
  - if it is above the target, the gain falls by one;
  - if it is equal, the gain does not change.
- R6: An automatic loop never raises the gain when it is at or above `gain_ceil`, and never lowers it when it is at or below `gain_floor`.
- R7: While freeze (`ctl_freeze`=1) is set, measurement strobes leave both automatic gains unchanged. The held gain is released when freeze is cleared or when the path's mode is changed.
- R8: A control write with `ctl_c_sel`=1x makes the chroma path use the luma active gain. The chroma read-back then equals the luma read-back.
- R9: When a path returns to automatic mode, its loop starts from the gain that was active just before, so the read-back value does not step.
- R10: Luma measurements never alter the chroma gain, and chroma measurements never alter the luma gain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Input sample valid |
| y_in | input | 9 | Luma sample |
| c_in | input | 9 | Chroma sample |
| out_vld | output | 1 | Output sample valid |
| y_out | output | 9 | Scaled luma sample |
| c_out | output | 9 | Scaled chroma sample |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_y_manual | input | 1 | Luma mode: 0 automatic, 1 manual |
| ctl_c_sel | input | 2 | Chroma mode: 00 automatic, 01 manual, 1x follow luma |
| ctl_freeze | input | 1 | Freeze both automatic loops |
| man_y_wr | input | 1 | Write the luma manual gain |
| man_c_wr | input | 1 | Write the chroma manual gain |
| man_gain | input | 12 | Manual gain write data |
| y_meas_vld | input | 1 | Luma amplitude measurement strobe |
| y_meas | input | 9 | Luma measured amplitude |
| c_meas_vld | input | 1 | Chroma amplitude measurement strobe |
| c_meas | input | 9 | Chroma measured amplitude |
| y_target | input | 9 | Luma loop target amplitude |
| c_target | input | 9 | Chroma loop target amplitude |
| gain_floor | input | 12 | Lower limit for automatic gains |
| gain_ceil | input | 12 | Upper limit for automatic gains |
| y_gain_rd | output | 12 | Luma gain currently active |
| c_gain_rd | output | 12 | Chroma gain currently active |

## Verification
The hardest case to reach is a loop that has been frozen or overridden and is then released. Freeze must hold the loop's value through many strobes. A later return to automatic mode must resume from whatever gain was active, even when that gain lies outside the floor/ceiling window. The stimulus drives the luma loop into its ceiling and freezes it while strobes keep arriving. It then forces a manual gain far above the ceiling and switches the path back to automatic. The test checks that the first downward strobe yields the manual value minus one, and that upward strobes have no effect. Chroma-follows-luma is checked at the same time, so that the loop-tracking behaviour of one path is seen not to leak into the other.

// File: rtl/vgain_pkg.sv
package vgain_pkg;
   typedef enum logic [1:0] {
      PM_AUTO   = 2'b00,
      PM_MANUAL = 2'b01,
      PM_FOLLOW = 2'b10
   } path_mode_t;
endpackage

// File: rtl/vgain_agc.sv
module vgain_agc
   import vgain_pkg::*;
#(
   parameter int GW     = 12,
   parameter int MW     = 9,
   parameter int GFRAC  = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  path_mode_t    mode,
   input  logic          freeze,
   input  logic          man_wr,
   input  logic [GW-1:0] man_data,
   input  logic [GW-1:0] follow_gain,
   input  logic          meas_vld,
   input  logic [MW-1:0] meas,
   input  logic [MW-1:0] target,
   input  logic [GW-1:0] gmin,
   input  logic [GW-1:0] gmax,
   output logic [GW-1:0] gain_act
);
   localparam logic [GW-1:0] UNITY = GW'(1) << GFRAC;

   logic [GW-1:0] man_q;
   logic [GW-1:0] loop_q;
   logic [GW-1:0] loop_nxt;

   always_comb begin
      unique case (mode)
         PM_MANUAL: gain_act = man_q;
         PM_FOLLOW: gain_act = follow_gain;
         default:   gain_act = loop_q;
      endcase
   end

   always_comb begin
      loop_nxt = loop_q;
      if (mode != PM_AUTO) begin
         loop_nxt = gain_act;
      end else if (meas_vld && !freeze) begin
         if (meas < target && loop_q < gmax)
            loop_nxt = loop_q + GW'(1);
         else if (meas > target && loop_q > gmin)
            loop_nxt = loop_q - GW'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         man_q  <= UNITY;
         loop_q <= UNITY;
      end else begin
         if (man_wr) man_q <= man_data;
         loop_q <= loop_nxt;
      end
   end
endmodule

// File: rtl/vgain_mult.sv
module vgain_mult #(
   parameter int DW    = 9,
   parameter int GW    = 12,
   parameter int GFRAC = 10,
   parameter bit ROUND = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_vld,
   input  logic [DW-1:0] x_in,
   input  logic [GW-1:0] g_in,
   output logic          out_vld,
   output logic [DW-1:0] x_out
);
   localparam int PW = DW + GW;
   localparam int SW = PW + 1 - GFRAC;
   localparam logic [SW-1:0] XMAX = SW'((1 << DW) - 1);

   logic          s1_vld;
   logic [DW-1:0] s1_x;
   logic [GW-1:0] s1_g;
   logic [PW:0]   prod;
   logic [SW-1:0] scaled;
   logic [DW-1:0] sat;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_vld <= 1'b0;
         s1_x   <= '0;
         s1_g   <= '0;
      end else begin
         s1_vld <= in_vld;
         s1_x   <= x_in;
         s1_g   <= g_in;
      end
   end

   generate
      if (ROUND) begin : g_round
         assign prod = ({1'b0, PW'(s1_x) * PW'(s1_g)}) + ((PW+1)'(1) << (GFRAC - 1));
      end else begin : g_trunc
         assign prod = {1'b0, PW'(s1_x) * PW'(s1_g)};
      end
   endgenerate

   assign scaled = prod[PW:GFRAC];
   assign sat    = (scaled > XMAX) ? XMAX[DW-1:0] : scaled[DW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_vld <= 1'b0;
         x_out   <= '0;
      end else begin
         out_vld <= s1_vld;
         x_out   <= sat;
      end
   end
endmodule

// File: rtl/vid_gain_ctrl.sv
module vid_gain_ctrl
   import vgain_pkg::*;
#(
   parameter int DW    = 9,
   parameter int GW    = 12,
   parameter int GFRAC = 10,
   parameter bit ROUND = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_vld,
   input  logic [DW-1:0] y_in,
   input  logic [DW-1:0] c_in,
   output logic          out_vld,
   output logic [DW-1:0] y_out,
   output logic [DW-1:0] c_out,
   input  logic          ctl_wr,
   input  logic          ctl_y_manual,
   input  logic [1:0]    ctl_c_sel,
   input  logic          ctl_freeze,
   input  logic          man_y_wr,
   input  logic          man_c_wr,
   input  logic [GW-1:0] man_gain,
   input  logic          y_meas_vld,
   input  logic [DW-1:0] y_meas,
   input  logic          c_meas_vld,
   input  logic [DW-1:0] c_meas,
   input  logic [DW-1:0] y_target,
   input  logic [DW-1:0] c_target,
   input  logic [GW-1:0] gain_floor,
   input  logic [GW-1:0] gain_ceil,
   output logic [GW-1:0] y_gain_rd,
   output logic [GW-1:0] c_gain_rd
);
   initial begin
      if (GFRAC < 1 || GFRAC >= GW) $error("vid_gain_ctrl: GFRAC must lie in 1..GW-1");
      if (DW < 2) $error("vid_gain_ctrl: DW too small");
   end

   path_mode_t ymode_q, cmode_q;
   logic       freeze_q;
   logic       c_out_vld;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ymode_q  <= PM_AUTO;
         cmode_q  <= PM_AUTO;
         freeze_q <= 1'b0;
      end else if (ctl_wr) begin
         ymode_q  <= ctl_y_manual ? PM_MANUAL : PM_AUTO;
         cmode_q  <= ctl_c_sel[1] ? PM_FOLLOW : (ctl_c_sel[0] ? PM_MANUAL : PM_AUTO);
         freeze_q <= ctl_freeze;
      end
   end

   vgain_agc #(.GW(GW), .MW(DW), .GFRAC(GFRAC)) u_agc_y (
      .clk(clk), .rst_n(rst_n), .mode(ymode_q), .freeze(freeze_q),
      .man_wr(man_y_wr), .man_data(man_gain), .follow_gain('0),
      .meas_vld(y_meas_vld), .meas(y_meas), .target(y_target),
      .gmin(gain_floor), .gmax(gain_ceil), .gain_act(y_gain_rd)
   );

   vgain_agc #(.GW(GW), .MW(DW), .GFRAC(GFRAC)) u_agc_c (
      .clk(clk), .rst_n(rst_n), .mode(cmode_q), .freeze(freeze_q),
      .man_wr(man_c_wr), .man_data(man_gain), .follow_gain(y_gain_rd),
      .meas_vld(c_meas_vld), .meas(c_meas), .target(c_target),
      .gmin(gain_floor), .gmax(gain_ceil), .gain_act(c_gain_rd)
   );

   vgain_mult #(.DW(DW), .GW(GW), .GFRAC(GFRAC), .ROUND(ROUND)) u_mul_y (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .x_in(y_in), .g_in(y_gain_rd),
      .out_vld(out_vld), .x_out(y_out)
   );

   vgain_mult #(.DW(DW), .GW(GW), .GFRAC(GFRAC), .ROUND(ROUND)) u_mul_c (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .x_in(c_in), .g_in(c_gain_rd),
      .out_vld(c_out_vld), .x_out(c_out)
   );
endmodule

// File: rtl/vgain_chk.sv
module vgain_chk
   import vgain_pkg::*;
#(
   parameter int GW = 12
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_vld,
   input logic          out_vld,
   input path_mode_t    ymode_q,
   input path_mode_t    cmode_q,
   input logic          freeze_q,
   input logic [GW-1:0] y_gain_rd,
   input logic [GW-1:0] c_gain_rd,
   input logic [GW-1:0] gain_floor,
   input logic [GW-1:0] gain_ceil
);
   // R2
   latency_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |-> ##2 out_vld);

   // R2
   latency_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |-> ##2 !out_vld);

   // R5
   y_step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ymode_q == PM_AUTO && $past(ymode_q) == PM_AUTO) |->
      (y_gain_rd == $past(y_gain_rd) || y_gain_rd == $past(y_gain_rd) + GW'(1)
       || y_gain_rd == $past(y_gain_rd) - GW'(1)));

   // R7
   y_freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(freeze_q) && $past(ymode_q) == PM_AUTO && ymode_q == PM_AUTO) |-> $stable(y_gain_rd));

   // R7
   c_freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(freeze_q) && $past(cmode_q) == PM_AUTO && cmode_q == PM_AUTO) |-> $stable(c_gain_rd));

   // R6
   y_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ymode_q == PM_AUTO && $past(ymode_q) == PM_AUTO && $stable(gain_ceil) && $stable(gain_floor)
       && y_gain_rd > $past(y_gain_rd)) |-> y_gain_rd <= gain_ceil);

   // R8
   follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmode_q == PM_FOLLOW) |-> (c_gain_rd == y_gain_rd));
endmodule

bind vid_gain_ctrl vgain_chk #(.GW(GW)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .out_vld(out_vld),
   .ymode_q(ymode_q), .cmode_q(cmode_q), .freeze_q(freeze_q),
   .y_gain_rd(y_gain_rd), .c_gain_rd(c_gain_rd),
   .gain_floor(gain_floor), .gain_ceil(gain_ceil)
);

// File: tb/sim_vid_gain_ctrl.sv
module sim_vid_gain_ctrl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_vld = 0;
   logic [8:0] y_in = 0, c_in = 0;
   logic out_vld;
   logic [8:0] y_out, c_out;
   logic ctl_wr = 0, ctl_y_manual = 0, ctl_freeze = 0;
   logic [1:0] ctl_c_sel = 0;
   logic man_y_wr = 0, man_c_wr = 0;
   logic [11:0] man_gain = 0;
   logic y_meas_vld = 0, c_meas_vld = 0;
   logic [8:0] y_meas = 0, c_meas = 0;
   logic [8:0] y_target = 9'd200, c_target = 9'd100;
   logic [11:0] gain_floor = 12'h3F0, gain_ceil = 12'h410;
   logic [11:0] y_gain_rd, c_gain_rd;

   always #5 clk = ~clk;

   vid_gain_ctrl u0 (.*);

   int checks = 0, failures = 0;
   bit done = 0;

   // bench model of the requirement-level state
   logic [11:0] m_man_y = 12'h400, m_man_c = 12'h400, m_loop_y = 12'h400, m_loop_c = 12'h400;
   int m_ym = 0, m_cm = 0;
   bit m_frz = 0;
   logic [17:0] sbq[$];

   function automatic logic [11:0] act_y();
      return (m_ym == 1) ? m_man_y : m_loop_y;
   endfunction
   function automatic logic [11:0] act_c();
      return (m_cm == 1) ? m_man_c : (m_cm == 2) ? act_y() : m_loop_c;
   endfunction
   function automatic logic [8:0] scale(logic [8:0] x, logic [11:0] g);
      int v;
      v = (int'(x) * int'(g) + 512) >>> 10;
      return (v > 511) ? 9'd511 : 9'(v);
   endfunction
   function automatic logic [11:0] stepg(logic [11:0] g, logic [8:0] m, logic [8:0] t);
      if (m < t && g < gain_ceil) return g + 12'd1;
      if (m > t && g > gain_floor) return g - 12'd1;
      return g;
   endfunction

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one clock: inputs are already driven; update model, push expectations, clear strobes
   task automatic cyc();
      logic [11:0] ay, ac;
      ay = act_y(); ac = act_c();
      if (in_vld) sbq.push_back({scale(y_in, ay), scale(c_in, ac)});
      @(posedge clk);
      if (m_ym != 0) m_loop_y = ay;
      else if (y_meas_vld && !m_frz) m_loop_y = stepg(m_loop_y, y_meas, y_target);
      if (m_cm != 0) m_loop_c = ac;
      else if (c_meas_vld && !m_frz) m_loop_c = stepg(m_loop_c, c_meas, c_target);
      if (man_y_wr) m_man_y = man_gain;
      if (man_c_wr) m_man_c = man_gain;
      if (ctl_wr) begin
         m_ym = ctl_y_manual;
         m_cm = ctl_c_sel[1] ? 2 : int'(ctl_c_sel[0]);
         m_frz = ctl_freeze;
      end
      @(negedge clk);
      in_vld = 0; ctl_wr = 0; man_y_wr = 0; man_c_wr = 0; y_meas_vld = 0; c_meas_vld = 0;
   endtask

   task automatic sample(logic [8:0] y, logic [8:0] c);
      in_vld = 1; y_in = y; c_in = c; cyc();
   endtask
   task automatic meas_y(logic [8:0] m);
      y_meas_vld = 1; y_meas = m; cyc();
   endtask
   task automatic meas_c(logic [8:0] m);
      c_meas_vld = 1; c_meas = m; cyc();
   endtask
   task automatic ctl(bit ym, logic [1:0] cs, bit fz);
      ctl_wr = 1; ctl_y_manual = ym; ctl_c_sel = cs; ctl_freeze = fz; cyc();
   endtask
   task automatic man(bit path_c, logic [11:0] g);
      man_gain = g;
      if (path_c) man_c_wr = 1; else man_y_wr = 1;
      cyc();
   endtask
   task automatic flush();
      repeat (4) cyc();
      check("R2 scoreboard drained", sbq.size(), 0);
   endtask

   // monitor: compare produced samples against queued expectations
   always @(posedge clk) begin
      #2;
      if (rst_n && out_vld) begin
         if (sbq.size() == 0) check("R2 unexpected out_vld", 1, 0);
         else begin
            logic [17:0] e;
            e = sbq.pop_front();
            check("R2 R3 R4 R8 luma sample", y_out, e[17:9]);
            check("R2 R3 R4 R8 chroma sample", c_out, e[8:0]);
         end
      end
   end

   initial begin
      #2_000_000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      check("R1 luma gain", y_gain_rd, 12'h400);
      check("R1 chroma gain", c_gain_rd, 12'h400);
      check("R1 out_vld", out_vld, 0);
      // R2 unity gain, back-to-back and sparse
      sample(9'd100, 9'd37); sample(9'd511, 9'd0); cyc(); sample(9'd1, 9'd256);
      flush();
      // R5 R10 luma loop up/down/equal
      meas_y(9'd150); meas_y(9'd150); meas_y(9'd150);
      check("R5 luma up", y_gain_rd, 12'h403);
      check("R10 chroma untouched", c_gain_rd, 12'h400);
      meas_y(9'd250);
      check("R5 luma down", y_gain_rd, 12'h402);
      meas_y(9'd200);
      check("R5 luma equal", y_gain_rd, 12'h402);
      meas_c(9'd150);
      check("R10 luma untouched", y_gain_rd, 12'h402);
      check("R5 chroma down", c_gain_rd, 12'h3FF);
      // R6 ceiling and floor
      repeat (20) meas_y(9'd10);
      check("R6 luma ceiling", y_gain_rd, 12'h410);
      repeat (20) meas_c(9'd300);
      check("R6 chroma floor", c_gain_rd, 12'h3F0);
      sample(9'd300, 9'd300); sample(9'd17, 9'd511);
      flush();
      // R7 freeze holds
      ctl(0, 2'b00, 1);
      repeat (5) meas_y(9'd400);
      repeat (5) meas_c(9'd10);
      check("R7 luma frozen", y_gain_rd, 12'h410);
      check("R7 chroma frozen", c_gain_rd, 12'h3F0);
      ctl(0, 2'b00, 0);
      meas_y(9'd400);
      check("R7 luma unfrozen", y_gain_rd, 12'h40F);
      // R4 manual luma, takes effect on next sample
      man(0, 12'h800);
      check("R4 still auto before mode write", y_gain_rd, 12'h40F);
      ctl(1, 2'b00, 1);
      check("R4 R7 manual overrides hold", y_gain_rd, 12'h800);
      sample(9'd100, 9'd100); sample(9'd300, 9'd50);
      // R8 chroma follows luma
      ctl(1, 2'b10, 0);
      check("R8 follow readback", c_gain_rd, 12'h800);
      meas_c(9'd10);
      check("R8 follow ignores chroma meas", c_gain_rd, 12'h800);
      sample(9'd200, 9'd60);
      flush();
      // R9 back to auto, no step, then continue from active gain
      ctl(0, 2'b00, 0);
      check("R9 luma no step", y_gain_rd, 12'h800);
      check("R9 chroma no step", c_gain_rd, 12'h800);
      meas_y(9'd10);
      check("R6 R9 no rise above ceiling", y_gain_rd, 12'h800);
      meas_y(9'd400);
      check("R9 luma continues", y_gain_rd, 12'h7FF);
      // R3 saturation at maximum gain
      man(1, 12'hFFF);
      ctl(0, 2'b01, 0);
      check("R4 chroma manual", c_gain_rd, 12'hFFF);
      sample(9'd0, 9'd511); sample(9'd5, 9'd1); sample(9'd511, 9'd128);
      flush();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule